// File: doc/BRIEF.md
# Banked Non-Blocking Read Cache with Victim Store

This block is a read-only, direct-mapped first-level data cache. It is split into four banks, and each bank tracks one outstanding miss. A second, small direct-mapped store keeps the lines that were pushed out of the banks, so that a recently evicted line can come back without a memory trip. A requester presents a byte address and an identifier. The cache returns the whole 16-byte line with the same identifier, either one cycle later (bank hit or victim hit) or one cycle after memory fills the line.

A miss that also misses the victim store occupies the miss holder of its bank. That holder steps through three states: `MS_FREE` → `MS_ISSUE` on *alloc*, `MS_ISSUE` → `MS_WAIT` on *sent* (always after one cycle), and `MS_WAIT` → `MS_FREE` on *fill match*. In `MS_ISSUE` the holder drives the memory request port for exactly one cycle with the line address. When a fill arrives, the line it displaces from the bank moves into the victim store, and the waiting requester gets its response. Hits to any bank, and misses to a bank whose holder is free, keep flowing while other banks wait.

Top module: `banked_victim_cache`

## Requirements
- R1: After reset every bank line and victim entry is invalid, `req_ready` is high, and `rsp_valid` and `mem_req_valid` are low. The first access to any line goes to memory.
- R2: The request address splits into tag [31:16], line index [15:6], bank [5:4] and byte offset [3:0]. The line address is addr[31:4]. Two addresses that differ only in the offset hit the same line.
- R3: A request accepted while its line is valid in its bank produces `rsp_valid` in the next cycle, with the request's identifier and the line data.
- R4: A request that misses both the bank and the victim store, and is accepted, raises `mem_req_valid` in the next cycle with `mem_req_line` equal to addr[31:4]. It produces no response until the fill.
- R5: A fill whose line matches a waiting miss installs the line in its bank. The fill also produces `rsp_valid` in the next cycle, with the stored identifier and the fill data, and frees the holder.
- R6: While one bank has a miss outstanding, requests to other banks are accepted without stall, whether they hit or miss.
- R7: A miss to a bank whose holder is busy keeps `req_ready` low until that holder's fill. The request is accepted in the cycle after the fill.
- R8: In any cycle with `mem_fill_valid` high, `req_ready` is low.
- R9: A fill that replaces a valid bank line writes the old line into victim entry line[3:0], with tag line[27:4]. This overwrites the entry's previous line, so a later access to that previous line goes to memory.
- R10: A request that misses its bank but hits the victim store swaps the two lines. It responds in the next cycle and issues no memory request.
- R11: A holder leaves `MS_ISSUE` after one cycle, so each miss produces a single-cycle `mem_req_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request is accepted this cycle |
| req_addr | input | 32 | Byte address of the request |
| req_id | input | 4 | Requester identifier |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | 4 | Identifier of the answered request |
| rsp_data | output | 128 | Returned line |
| mem_req_valid | output | 1 | Memory read request (one-cycle pulse) |
| mem_req_line | output | 28 | Line address to read |
| mem_fill_valid | input | 1 | Memory fill present |
| mem_fill_line | input | 28 | Line address of the fill |
| mem_fill_data | input | 128 | Fill line data |

## Verification
Every result of this block has a fixed distance from the edge that causes it. A bank or victim hit answers in the cycle after the accepting edge. A miss raises its memory request in the cycle after acceptance and drops it in the cycle after that. A fill answers in the cycle after the fill edge. A stalled request is accepted at the edge just after its bank's fill. The driver tags each expected response with the cycle index of its cause, and the monitor samples on falling edges and checks both the content and that the response lands in that exact cycle. Unanswered or early responses count as mismatches.

// File: rtl/vcache_pkg.sv
package vcache_pkg;

    // Life cycle of one per-bank miss holder
    typedef enum logic [1:0] {
        MS_FREE  = 2'd0,
        MS_ISSUE = 2'd1,
        MS_WAIT  = 2'd2
    } mshr_state_e;

endpackage

// File: rtl/vc_dm_store.sv
// Direct-mapped line store with combinational lookup and one write port.
// Used for the cache banks and for the victim store.
module vc_dm_store #(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 16,
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic              lk_vld,
    output logic [TAG_W-1:0]  lk_tag_q,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic              wr_vld,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= wr_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign lk_vld   = vld_q[lk_idx];
    assign lk_tag_q = tag_q[lk_idx];
    assign lk_data  = data_q[lk_idx];
    assign lk_hit   = lk_vld && (lk_tag_q == lk_tag);

endmodule

// File: rtl/vc_mshr.sv
// One miss holder: remembers the line and requester of a pending miss.
module vc_mshr
    import vcache_pkg::*;
#(
    parameter int LINE_W = 28,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic [ID_W-1:0]   alloc_id,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    output logic              busy,
    output logic              issue,
    output logic              fill_hit,
    output logic [LINE_W-1:0] line,
    output logic [ID_W-1:0]   id
);
    mshr_state_e       st_q, st_d;
    logic [LINE_W-1:0] line_q;
    logic [ID_W-1:0]   id_q;
    logic              match_w;

    assign match_w = fill_valid && (fill_line == line_q);

    // state register and captured miss
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= MS_FREE;
            line_q <= '0;
            id_q   <= '0;
        end else begin
            st_q <= st_d;
            if (alloc && st_q == MS_FREE) begin
                line_q <= alloc_line;
                id_q   <= alloc_id;
            end
        end
    end

    // transitions: alloc, sent, fill match
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MS_FREE:  if (alloc)   st_d = MS_ISSUE;
            MS_ISSUE:              st_d = MS_WAIT;
            MS_WAIT:  if (match_w) st_d = MS_FREE;
            default:               st_d = MS_FREE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        issue    = 1'b0;
        fill_hit = 1'b0;
        unique case (st_q)
            MS_FREE:  busy     = 1'b0;
            MS_ISSUE: issue    = 1'b1;
            MS_WAIT:  fill_hit = match_w;
            default:  busy     = 1'b0;
        endcase
    end

    assign line = line_q;
    assign id   = id_q;

endmodule

// File: rtl/banked_victim_cache.sv
module banked_victim_cache
    import vcache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int BANK_W = 2,
    parameter int IDX_W  = 10,
    parameter int VIDX_W = 4,
    parameter int ID_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [ID_W-1:0]               req_id,
    output logic                          rsp_valid,
    output logic [ID_W-1:0]               rsp_id,
    output logic [(8<<OFF_W)-1:0]         rsp_data,
    output logic                          mem_req_valid,
    output logic [ADDR_W-OFF_W-1:0]       mem_req_line,
    input  logic                          mem_fill_valid,
    input  logic [ADDR_W-OFF_W-1:0]       mem_fill_line,
    input  logic [(8<<OFF_W)-1:0]         mem_fill_data
);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int TAG_W  = LINE_W - BANK_W - IDX_W;
    localparam int VTAG_W = LINE_W - VIDX_W;
    localparam int DATA_W = 8 << OFF_W;
    localparam int NBANK  = 1 << BANK_W;

    // ---------------- address split ----------------
    logic [LINE_W-1:0] req_line, look_line, disp_line;
    logic [BANK_W-1:0] look_bank;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic [VIDX_W-1:0] look_vidx;
    logic [VTAG_W-1:0] look_vtag;
    logic [OFF_W-1:0]  unused_offset;

    assign req_line      = req_addr[ADDR_W-1:OFF_W];
    assign unused_offset = req_addr[OFF_W-1:0];
    // a fill owns the lookup path in its cycle; requests wait
    assign look_line = mem_fill_valid ? mem_fill_line : req_line;
    assign look_bank = look_line[BANK_W-1:0];
    assign look_idx  = look_line[BANK_W +: IDX_W];
    assign look_tag  = look_line[LINE_W-1 -: TAG_W];
    assign look_vidx = look_line[VIDX_W-1:0];
    assign look_vtag = look_line[LINE_W-1:VIDX_W];

    // ---------------- banks ----------------
    logic              bk_hit  [NBANK];
    logic              bk_vld  [NBANK];
    logic [TAG_W-1:0]  bk_tagq [NBANK];
    logic [DATA_W-1:0] bk_data [NBANK];
    logic              l1_wr;
    logic [DATA_W-1:0] l1_wdata;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            vc_dm_store #(
                .IDX_W (IDX_W),
                .TAG_W (TAG_W),
                .DATA_W(DATA_W)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .lk_idx  (look_idx),
                .lk_tag  (look_tag),
                .lk_hit  (bk_hit[b]),
                .lk_vld  (bk_vld[b]),
                .lk_tag_q(bk_tagq[b]),
                .lk_data (bk_data[b]),
                .wr_en   (l1_wr && (look_bank == BANK_W'(b))),
                .wr_vld  (1'b1),
                .wr_idx  (look_idx),
                .wr_tag  (look_tag),
                .wr_data (l1_wdata)
            );
        end
    endgenerate

    logic              sel_hit, sel_vld;
    logic [TAG_W-1:0]  sel_tagq;
    logic [DATA_W-1:0] sel_data;

    assign sel_hit  = bk_hit[look_bank];
    assign sel_vld  = bk_vld[look_bank];
    assign sel_tagq = bk_tagq[look_bank];
    assign sel_data = bk_data[look_bank];

    // the displaced line shares bank and index, hence the victim slot
    assign disp_line = {sel_tagq, look_idx, look_bank};

    // ---------------- victim store ----------------
    logic              v_hit, v_vld_unused, v_we, v_wvld;
    logic [VTAG_W-1:0] v_tagq_unused;
    logic [DATA_W-1:0] v_data;

    vc_dm_store #(
        .IDX_W (VIDX_W),
        .TAG_W (VTAG_W),
        .DATA_W(DATA_W)
    ) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_idx  (look_vidx),
        .lk_tag  (look_vtag),
        .lk_hit  (v_hit),
        .lk_vld  (v_vld_unused),
        .lk_tag_q(v_tagq_unused),
        .lk_data (v_data),
        .wr_en   (v_we),
        .wr_vld  (v_wvld),
        .wr_idx  (look_vidx),
        .wr_tag  (disp_line[LINE_W-1:VIDX_W]),
        .wr_data (sel_data)
    );

    // ---------------- miss holders ----------------
    logic [NBANK-1:0]  mshr_busy, mshr_issue, mshr_fhit, mshr_alloc;
    logic [LINE_W-1:0] mshr_line [NBANK];
    logic [ID_W-1:0]   mshr_id   [NBANK];

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_mshr
            vc_mshr #(
                .LINE_W(LINE_W),
                .ID_W  (ID_W)
            ) u_mshr (
                .clk       (clk),
                .rst_n     (rst_n),
                .alloc     (mshr_alloc[b]),
                .alloc_line(req_line),
                .alloc_id  (req_id),
                .fill_valid(mem_fill_valid),
                .fill_line (mem_fill_line),
                .busy      (mshr_busy[b]),
                .issue     (mshr_issue[b]),
                .fill_hit  (mshr_fhit[b]),
                .line      (mshr_line[b]),
                .id        (mshr_id[b])
            );
        end
    endgenerate

    // ---------------- request / fill control ----------------
    logic req_vhit, req_miss, sel_busy, acc, fill_do;

    assign req_vhit  = !sel_hit && v_hit;
    assign req_miss  = !sel_hit && !v_hit;
    assign sel_busy  = mshr_busy[look_bank];
    assign fill_do   = |mshr_fhit;
    assign req_ready = !mem_fill_valid && !(req_miss && sel_busy);
    assign acc       = req_valid && req_ready;

    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            mshr_alloc[b] = acc && req_miss && (look_bank == BANK_W'(b));
        end
    end

    // bank write: fill install, or victim line swapped back in
    assign l1_wr    = fill_do || (acc && req_vhit);
    assign l1_wdata = fill_do ? mem_fill_data : v_data;

    // victim write: take the displaced line; on a swap into an empty
    // bank slot the victim entry is dropped
    assign v_we   = (fill_do && sel_vld) || (acc && req_vhit);
    assign v_wvld = sel_vld;

    // memory request: at most one holder is in MS_ISSUE at a time
    always_comb begin
        mem_req_valid = |mshr_issue;
        mem_req_line  = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (mshr_issue[b]) mem_req_line = mem_req_line | mshr_line[b];
        end
    end

    // ---------------- response register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= fill_do || (acc && !req_miss);
            if (fill_do) begin
                rsp_id   <= mshr_id[look_bank];
                rsp_data <= mem_fill_data;
            end else if (acc && !req_miss) begin
                rsp_id   <= req_id;
                rsp_data <= sel_hit ? sel_data : v_data;
            end
        end
    end

endmodule

// File: rtl/vcache_chk.sv
module vcache_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int ID_W   = 4,
    parameter int NBANK  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [ADDR_W-1:0]       req_addr,
    input logic [ID_W-1:0]         req_id,
    input logic                    rsp_valid,
    input logic [ID_W-1:0]         rsp_id,
    input logic [(8<<OFF_W)-1:0]   rsp_data,
    input logic                    mem_req_valid,
    input logic [ADDR_W-OFF_W-1:0] mem_req_line,
    input logic                    mem_fill_valid,
    input logic [(8<<OFF_W)-1:0]   mem_fill_data,
    input logic                    req_miss,
    input logic                    sel_busy,
    input logic                    fill_do,
    input logic [NBANK-1:0]        issue_vec
);
    // R3: hit answers in the next cycle with its identifier
    a_r3_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_miss) |=> (rsp_valid && rsp_id == $past(req_id)));

    // R10: a hit (bank or victim) leads to no memory request
    a_r10_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_miss) |=> !mem_req_valid);

    // R4: accepted double miss raises the memory request next cycle
    a_r4_req_after_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_miss) |=>
            (mem_req_valid && mem_req_line == $past(req_addr[ADDR_W-1:OFF_W])));

    // R7: a miss is only accepted when its bank's holder is free
    a_r7_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_miss) |-> !sel_busy);

    // R8: fills block requests
    a_r8_fill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mem_fill_valid |-> !req_ready);

    // R5: a matched fill answers next cycle with the fill data
    a_r5_fill_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        fill_do |=> (rsp_valid && rsp_data == $past(mem_fill_data)));

    // R11: never more than one holder issuing
    a_r11_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_vec));

endmodule

bind banked_victim_cache vcache_chk #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .ID_W  (ID_W),
    .NBANK (NBANK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_id        (req_id),
    .rsp_valid     (rsp_valid),
    .rsp_id        (rsp_id),
    .rsp_data      (rsp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_line  (mem_req_line),
    .mem_fill_valid(mem_fill_valid),
    .mem_fill_data (mem_fill_data),
    .req_miss      (req_miss),
    .sel_busy      (sel_busy),
    .fill_do       (fill_do),
    .issue_vec     (mshr_issue)
);

// File: tb/sim_banked_victim_cache.sv
module sim_banked_victim_cache;
    localparam int ID_W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [3:0]   req_id = '0;
    logic         rsp_valid;
    logic [3:0]   rsp_id;
    logic [127:0] rsp_data;
    logic         mem_req_valid;
    logic [27:0]  mem_req_line;
    logic         mem_fill_valid = 1'b0;
    logic [27:0]  mem_fill_line = '0;
    logic [127:0] mem_fill_data = '0;

    always #4 clk = ~clk;   // 125 MHz

    banked_victim_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_id(req_id),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
        .mem_fill_valid(mem_fill_valid), .mem_fill_line(mem_fill_line),
        .mem_fill_data(mem_fill_data)
    );

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [3:0]   id;
        logic [127:0] data;
        int           due;
        string        tag;
    } exp_t;

    exp_t        sbq[$];
    logic [27:0] memq[$];

    function automatic logic [127:0] line_data(input logic [27:0] l);
        return {4'hA, l, 4'hB, ~l, 4'hC, l ^ 28'h5A5A5A5, 4'hD, l + 28'd7};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_req_valid) memq.push_back(mem_req_line);
            if (rsp_valid) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R3", "unexpected response id", 128'(rsp_id), 128'(0));
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(rsp_data == e.data, e.tag, "response data", rsp_data, e.data);
                    check(rsp_id == e.id, e.tag, "response id", 128'(rsp_id), 128'(e.id));
                    check(cyc == e.due, e.tag, "response cycle", 128'(cyc), 128'(e.due));
                end
            end else if (sbq.size() > 0 && sbq[0].due <= cyc) begin
                exp_t e;
                e = sbq.pop_front();
                check(1'b0, e.tag, "missing response cycle", 128'(cyc), 128'(e.due));
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic send(input logic [31:0] a, input logic [3:0] id,
                        output int acc_cyc, output int stalls);
        bit rdy;
        req_valid = 1'b1; req_addr = a; req_id = id; stalls = 0;
        forever begin
            @(negedge clk); rdy = req_ready;
            @(posedge clk); #1;
            if (rdy) break;
            stalls++;
        end
        req_valid = 1'b0;
        acc_cyc = cyc;
    endtask

    task automatic hit(input logic [31:0] a, input logic [3:0] id, input string tag);
        int ac, st;
        send(a, id, ac, st);
        check(st == 0, tag, "hit stalled", 128'(st), 128'(0));
        sbq.push_back('{id: id, data: line_data(a[31:4]), due: ac, tag: tag});
    endtask

    task automatic miss(input logic [31:0] a, input logic [3:0] id, input string tag);
        int ac, st;
        send(a, id, ac, st);
        check(st == 0, tag, "miss stalled", 128'(st), 128'(0));
    endtask

    task automatic expect_memreq(input logic [27:0] l, input string tag);
        logic [27:0] got;
        @(negedge clk); #1;
        check(memq.size() == 1, tag, "memory request count", 128'(memq.size()), 128'(1));
        got = (memq.size() > 0) ? memq.pop_front() : 28'hFFFFFFF;
        check(got == l, tag, "memory request line", 128'(got), 128'(l));
        @(negedge clk); #1;
        check(!mem_req_valid, "R11", "request pulse length", 128'(mem_req_valid), 128'(0));
        @(posedge clk); #1;
    endtask

    task automatic fill(input logic [27:0] l, input logic [3:0] id, input string tag);
        mem_fill_valid = 1'b1; mem_fill_line = l; mem_fill_data = line_data(l);
        @(posedge clk); #1;
        mem_fill_valid = 1'b0;
        sbq.push_back('{id: id, data: line_data(l), due: cyc, tag: tag});
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        int acc_d, st_d, fill_c;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        check(req_ready == 1'b1, "R1", "ready after reset", 128'(req_ready), 128'(1));
        check(rsp_valid == 1'b0, "R1", "rsp after reset", 128'(rsp_valid), 128'(0));
        check(mem_req_valid == 1'b0, "R1", "memreq after reset", 128'(mem_req_valid), 128'(0));

        // R1/R4: first access misses and goes to memory
        miss(32'h0000_1000, 4'd1, "R4");
        expect_memreq(28'h0000100, "R1");
        idle(2);
        fill(28'h0000100, 4'd1, "R5");
        idle(1);

        // R2: other offset of same line hits; R3: plain hit
        hit(32'h0000_100C, 4'd2, "R2");
        hit(32'h0000_1000, 4'd3, "R3");
        idle(2);
        check(memq.size() == 0, "R3", "hit made memory request", 128'(memq.size()), 128'(0));

        // R6: other banks proceed while bank 2 waits
        miss(32'h0000_1020, 4'd4, "R4");
        expect_memreq(28'h0000102, "R4");
        hit(32'h0000_1004, 4'd5, "R6");
        miss(32'h0000_2030, 4'd6, "R6");
        expect_memreq(28'h0000203, "R6");

        // R7: second miss to busy bank 2 waits for its fill
        fork
            begin send(32'h0000_3020, 4'd7, acc_d, st_d); end
            begin idle(3); fill(28'h0000102, 4'd4, "R5"); fill_c = cyc; end
        join
        check(acc_d == fill_c + 1, "R7", "accept cycle after fill", 128'(acc_d), 128'(fill_c + 1));
        check(st_d > 0, "R7", "stall seen", 128'(st_d), 128'(1));
        expect_memreq(28'h0000302, "R7");
        fill(28'h0000203, 4'd6, "R5");
        fill(28'h0000302, 4'd7, "R5");
        hit(32'h0000_1024, 4'd8, "R3");
        idle(2);

        // R9/R10: conflict eviction into victim store, then swaps
        miss(32'h0001_1000, 4'd9, "R4");
        expect_memreq(28'h0001100, "R4");
        fill(28'h0001100, 4'd9, "R9");
        hit(32'h0000_1000, 4'd10, "R10");
        hit(32'h0001_1008, 4'd11, "R10");
        hit(32'h0000_1000, 4'd12, "R10");
        idle(2);
        check(memq.size() == 0, "R10", "victim hit made memory request", 128'(memq.size()), 128'(0));

        // R9: a third conflicting line overwrites the victim entry
        miss(32'h0002_1000, 4'd13, "R4");
        expect_memreq(28'h0002100, "R9");
        fill(28'h0002100, 4'd13, "R9");
        hit(32'h0000_1000, 4'd14, "R9");
        miss(32'h0001_1000, 4'd15, "R9");
        expect_memreq(28'h0001100, "R9");
        fill(28'h0001100, 4'd15, "R5");
        idle(1);

        // R8: a fill in the same cycle blocks a request that would hit
        miss(32'h0000_1010, 4'd0, "R6");
        expect_memreq(28'h0000101, "R4");
        req_valid = 1'b1; req_addr = 32'h0000_1020; req_id = 4'd2;
        mem_fill_valid = 1'b1; mem_fill_line = 28'h0000101; mem_fill_data = line_data(28'h0000101);
        @(negedge clk);
        check(req_ready == 1'b0, "R8", "ready during fill", 128'(req_ready), 128'(0));
        @(posedge clk); #1;
        mem_fill_valid = 1'b0;
        sbq.push_back('{id: 4'd0, data: line_data(28'h0000101), due: cyc, tag: "R5"});
        @(negedge clk);
        check(req_ready == 1'b1, "R8", "ready after fill", 128'(req_ready), 128'(1));
        @(posedge clk); #1;
        req_valid = 1'b0;
        sbq.push_back('{id: 4'd2, data: line_data(28'h0000102), due: cyc, tag: "R8"});

        idle(4);
        check(sbq.size() == 0, "R5", "responses outstanding", 128'(sbq.size()), 128'(0));
        check(memq.size() == 0, "R4", "stray memory requests", 128'(memq.size()), 128'(0));
        finish_run();
    end

endmodule